// File: doc/BRIEF.md
# Signed Binary to ASCII Decimal Converter

This block turns a 12-bit two's-complement number into five printable characters: a sign followed by four decimal digits. A requester sees `ready_o` high, pulses `start_i` for one cycle with the number on `value_i`, and may then change or drop the input. The block works out the magnitude and runs a shift-and-add-3 sequence, one input bit per clock. When it finishes it raises `done_o` for one cycle.

The five character outputs change only on the cycle that `done_o` rises. They keep their values until the next conversion completes. A consumer that prints the result emits the sign first, then `dig3_o`, `dig2_o`, `dig1_o` and `dig0_o`. Every digit is always printed, leading zeros included.

Top module: `sb2a_top`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `ready_o` is 1, `done_o` is 0, `sign_o` is 0x2B and all four digit outputs are 0x30, so the outputs read "+0000".
- R2: `value_i` is sampled only on the clock edge where `start_i` is high and `ready_o` is high. Any later change of `value_i` has no effect on the result.
- R3: `ready_o` goes low on the edge after an accepted start. It stays low until `done_o` rises and is high whenever `done_o` is high.
- R4: `done_o` rises exactly 12 clock edges after the accepting edge (one edge per input bit) and stays high for exactly one cycle.
- R5: A `start_i` pulse while `ready_o` is low is ignored. The running conversion keeps its value and its timing.
- R6: `sign_o` is 0x2D ('-') for a negative input and 0x2B ('+') for zero or a positive input.
- R7: Each digit output holds 0x30 plus one decimal digit of the magnitude. `dig3_o` holds thousands, `dig2_o` hundreds, `dig1_o` tens and `dig0_o` units. Leading zeros are kept.
- R8: The magnitude is 12-bit unsigned, so -2048 gives "-2048" and +2047 gives "+2047".
- R9: All five character outputs stay constant on every cycle in which `done_o` is not rising with a new result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request; accepted only when `ready_o` is high |
| value_i | input | 12 | Two's-complement value to convert |
| ready_o | output | 1 | High when a start will be accepted |
| done_o | output | 1 | One-cycle completion tick |
| sign_o | output | 8 | Sign character, '+' or '-' |
| dig3_o | output | 8 | Thousands digit character |
| dig2_o | output | 8 | Hundreds digit character |
| dig1_o | output | 8 | Tens digit character |
| dig0_o | output | 8 | Units digit character |

## Verification
The bench sweeps all 4096 input codes. This catches the two classic failures:
- A wrong negation of -2048, which shows up as a corrupted or sign-flipped magnitude.
- A misplaced add-3 threshold, which produces digits above 9 or off-by-three values near 5 and 10.

After each start the bench scrambles `value_i`, so a design that keeps sampling the input after the start produces wrong characters. Some conversions also get a second start in the middle of the run; a design that restarts would miss the 12-cycle completion point or return the intruding value. The bench also checks that `done_o` lasts one cycle and that the characters hold between results, which catches outputs that are driven from the working registers.

// File: rtl/sb2a_pkg.sv
package sb2a_pkg;

    parameter int VAL_W_DEF = 12;
    parameter int N_DIG     = 4;
    parameter int BCD_W     = 4 * N_DIG;

    typedef logic [7:0] char_t;

    localparam char_t CH_PLUS  = 8'h2B;
    localparam char_t CH_MINUS = 8'h2D;
    localparam char_t CH_ZERO  = 8'h30;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    function automatic char_t digit_char(input logic [3:0] d);
        return CH_ZERO + {4'h0, d};
    endfunction

    function automatic logic [3:0] adj3(input logic [3:0] d);
        return (d >= 4'd5) ? d + 4'd3 : d;
    endfunction

endpackage

// File: rtl/sb2a_sign_mag.sv
module sb2a_sign_mag #(
    parameter int W = 12
) (
    input  logic [W-1:0] val_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);
    always_comb begin
        neg_o = val_i[W-1];
        mag_o = neg_o ? (~val_i + W'(1)) : val_i;
    end
endmodule

// File: rtl/sb2a_bcd_step.sv
module sb2a_bcd_step
    import sb2a_pkg::*;
(
    input  logic [BCD_W-1:0] bcd_i,
    input  logic             bit_i,
    output logic [BCD_W-1:0] bcd_o
);
    logic [BCD_W-1:0] adj_w;

    for (genvar g = 0; g < N_DIG; g++) begin : g_adj
        assign adj_w[4*g +: 4] = adj3(bcd_i[4*g +: 4]);
    end

    assign bcd_o = {adj_w[BCD_W-2:0], bit_i};
endmodule

// File: rtl/sb2a_ascii_fmt.sv
module sb2a_ascii_fmt
    import sb2a_pkg::*;
(
    input  logic [BCD_W-1:0]          bcd_i,
    output logic [N_DIG-1:0][7:0]     chars_o
);
    for (genvar g = 0; g < N_DIG; g++) begin : g_chr
        assign chars_o[g] = digit_char(bcd_i[4*g +: 4]);
    end
endmodule

// File: rtl/sb2a_top.sv
module sb2a_top
    import sb2a_pkg::*;
#(
    parameter int VAL_W = VAL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [VAL_W-1:0] value_i,
    output logic             ready_o,
    output logic             done_o,
    output logic [7:0]       sign_o,
    output logic [7:0]       dig3_o,
    output logic [7:0]       dig2_o,
    output logic [7:0]       dig1_o,
    output logic [7:0]       dig0_o
);
    localparam int CNT_W = $clog2(VAL_W);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(VAL_W - 1);

    run_e                  state_q;
    logic                  neg_w, neg_q;
    logic [VAL_W-1:0]      mag_w, shf_q;
    logic [BCD_W-1:0]      bcd_q, bcd_nx;
    logic [CNT_W-1:0]      cnt_q;
    logic                  done_q;
    char_t                 sign_q;
    logic [N_DIG-1:0][7:0] dig_q, fmt_w;
    logic                  accept_w, last_w;

    sb2a_sign_mag #(.W(VAL_W)) sm_i (
        .val_i (value_i),
        .neg_o (neg_w),
        .mag_o (mag_w)
    );

    sb2a_bcd_step step_i (
        .bcd_i (bcd_q),
        .bit_i (shf_q[VAL_W-1]),
        .bcd_o (bcd_nx)
    );

    sb2a_ascii_fmt fmt_i (
        .bcd_i   (bcd_nx),
        .chars_o (fmt_w)
    );

    assign accept_w = (state_q == ST_IDLE) && start_i;
    assign last_w   = (cnt_q == LAST_CNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            neg_q   <= 1'b0;
            shf_q   <= '0;
            bcd_q   <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            sign_q  <= CH_PLUS;
            for (int i = 0; i < N_DIG; i++) dig_q[i] <= CH_ZERO;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_w) begin
                        state_q <= ST_RUN;
                        neg_q   <= neg_w;
                        shf_q   <= mag_w;
                        bcd_q   <= '0;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    bcd_q <= bcd_nx;
                    shf_q <= {shf_q[VAL_W-2:0], 1'b0};
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (last_w) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                        sign_q  <= neg_q ? CH_MINUS : CH_PLUS;
                        dig_q   <= fmt_w;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready_o = (state_q == ST_IDLE);
    assign done_o  = done_q;
    assign sign_o  = sign_q;
    assign dig3_o  = dig_q[3];
    assign dig2_o  = dig_q[2];
    assign dig1_o  = dig_q[1];
    assign dig0_o  = dig_q[0];
endmodule

// File: rtl/sb2a_checker.sv
module sb2a_checker #(
    parameter int VAL_W = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       ready_o,
    input logic       done_o,
    input logic [7:0] sign_o,
    input logic [7:0] dig3_o,
    input logic [7:0] dig2_o,
    input logic [7:0] dig1_o,
    input logic [7:0] dig0_o
);
    localparam int LW = $clog2(VAL_W + 2) + 1;

    logic          busy_q;
    logic [LW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
        end else if (start_i && ready_o) begin
            busy_q <= 1'b1;
            lat_q  <= '0;
        end else if (done_o) begin
            busy_q <= 1'b0;
        end else if (busy_q && lat_q <= LW'(VAL_W)) begin
            lat_q <= lat_q + LW'(1);
        end
    end

    // R4
    a_r4_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R4
    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_q && lat_q == LW'(VAL_W)));
    // R3
    a_r3_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ready_o);
    // R3
    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && ready_o) |=> !ready_o);
    // R5
    a_r5_busy_stays_low: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !done_o) |-> !ready_o);
    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(sign_o) && $stable(dig3_o) && $stable(dig2_o)
                     && $stable(dig1_o) && $stable(dig0_o)));
    // R6
    a_r6_sign_code: assert property (@(posedge clk) disable iff (rst)
        (sign_o == 8'h2B) || (sign_o == 8'h2D));
    // R7
    a_r7_digit_range: assert property (@(posedge clk) disable iff (rst)
        (dig3_o inside {[8'h30:8'h39]}) && (dig2_o inside {[8'h30:8'h39]})
        && (dig1_o inside {[8'h30:8'h39]}) && (dig0_o inside {[8'h30:8'h39]}));
endmodule

bind sb2a_top sb2a_checker #(.VAL_W(VAL_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .ready_o (ready_o),
    .done_o  (done_o),
    .sign_o  (sign_o),
    .dig3_o  (dig3_o),
    .dig2_o  (dig2_o),
    .dig1_o  (dig1_o),
    .dig0_o  (dig0_o)
);

// File: tb/sb2a_top_tb_top.sv
`timescale 1ns/1ps
module sb2a_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [11:0] value_i = '0;
    logic        ready_o, done_o;
    logic [7:0]  sign_o, dig3_o, dig2_o, dig1_o, dig0_o;

    int total = 0;
    int bad   = 0;
    bit ended = 1'b0;

    always #2.5 clk = ~clk;

    sb2a_top #(.VAL_W(12)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .value_i(value_i),
        .ready_o(ready_o), .done_o(done_o), .sign_o(sign_o),
        .dig3_o(dig3_o), .dig2_o(dig2_o), .dig1_o(dig1_o), .dig0_o(dig0_o)
    );

    function automatic logic [39:0] expect_chars(input logic [11:0] v);
        int s, m;
        logic [7:0] sg;
        s  = int'($signed(v));
        m  = (s < 0) ? -s : s;
        sg = (s < 0) ? 8'h2D : 8'h2B;
        return {sg, 8'(8'h30 + (m / 1000) % 10), 8'(8'h30 + (m / 100) % 10),
                8'(8'h30 + (m / 10) % 10), 8'(8'h30 + m % 10)};
    endfunction

    function automatic logic [39:0] got_chars();
        return {sign_o, dig3_o, dig2_o, dig1_o, dig0_o};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [39:0] act, input logic [39:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_conv(input logic [11:0] v, input bit intrude);
        int cyc;
        logic [39:0] exp, got;
        bit busy_ok;
        @(negedge clk);
        value_i = v;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        value_i = ~v ^ 12'h3C3;
        check(!ready_o && !done_o, "R3", "ready low after start",
              {38'b0, ready_o, done_o}, 40'h0);
        cyc = 0;
        busy_ok = 1'b1;
        while (!done_o && cyc < 40) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 5) begin
                start_i = 1'b1;
                value_i = v ^ 12'h5A5;
            end else begin
                start_i = 1'b0;
            end
            if (!done_o && ready_o) busy_ok = 1'b0;
        end
        start_i = 1'b0;
        check(busy_ok, intrude ? "R5" : "R3", "ready stayed low while busy",
              {39'b0, busy_ok}, 40'h1);
        check(cyc == 12 && done_o, intrude ? "R5" : "R4", "done latency",
              40'(cyc), 40'd12);
        check(ready_o, "R3", "ready high with done", {39'b0, ready_o}, 40'h1);
        exp = expect_chars(v);
        got = got_chars();
        check(got == exp, ($signed(v) < 0) ? "R6" : "R7", "characters", got, exp);
        if (v == 12'h800 || v == 12'h7FF)
            check(got == exp, "R8", "range end", got, exp);
        @(negedge clk);
        check(!done_o, "R4", "done one cycle", {39'b0, done_o}, 40'h0);
        check(got_chars() == got, "R9", "hold after done", got_chars(), got);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(ready_o && !done_o, "R1", "ready/done in reset",
              {38'b0, ready_o, done_o}, 40'h2);
        check(got_chars() == "+0000", "R1", "chars in reset", got_chars(), "+0000");
        rst = 1'b0;
        @(negedge clk);
        check(ready_o && !done_o && got_chars() == "+0000", "R1", "after release",
              got_chars(), "+0000");

        // R2 and R8: range ends with scrambled input after capture
        run_conv(12'h800, 1'b0);
        run_conv(12'h7FF, 1'b0);
        run_conv(12'h000, 1'b0);
        // R5: second start while busy
        run_conv(12'hFFB, 1'b1);
        run_conv(12'h4D2, 1'b1);

        // R9: long idle gap holds result
        begin
            logic [39:0] held;
            held = got_chars();
            value_i = 12'h123;
            repeat (7) @(negedge clk);
            check(got_chars() == held && !done_o, "R9", "idle hold",
                  got_chars(), held);
        end

        // R6 R7: exhaustive sweep
        for (int k = 0; k < 4096; k++) begin
            run_conv(12'(k), 1'b0);
        end

        ended = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule